// File: doc/BRIEF.md
# I2C Register Access Slave

This block lets an I2C bus master read and write a byte-wide register file inside the chip. It watches the SCL and SDA lines, which a system clock oversamples. A transaction opens with a start condition and a 7-bit device address. That address has three parts: a fixed upper nibble, two bits taken live from address pins, and one bit captured from a strap input while reset is held. The block answers only when the address matches. It acknowledges each byte it receives and drives read data onto SDA through an open-drain pull-low enable.

In a write, the first byte after the address is the pointer byte. Bit 7 of this byte is the auto-advance flag. The lower bits select a register. Each later data byte is written to the selected register through a single-cycle write strobe. In a read, the block sends the register that the pointer currently selects. A master that needs a chosen register writes the pointer first and then issues a repeated start to read. When the auto-advance flag is set, the pointer steps by one after every byte transferred in either direction, and it wraps at the top of the register space.

Top module: `i2c_regport_slave`

## Requirements
- R1: The slave acknowledges (pulls SDA low in the ninth bit) an address byte whose upper seven bits equal {4'b0010, strap, pin[1], pin[0]}, and does not acknowledge any other address.
- R2: The strap bit of the address is the strap input level while reset is asserted; changing the strap input after reset has no effect on matching.
- R3: Address bits 1 and 0 follow the address pins at the time of the transaction, without a reset.
- R4: After a non-matching address the slave acknowledges nothing, writes nothing and leaves SDA released until the next start.
- R5: In a write, the first data byte loads the pointer (bit 7 = auto-advance flag, bits 6..0 = register index) and every later byte produces one write strobe carrying that byte to the pointed register; each received byte is acknowledged.
- R6: With the auto-advance flag set, successive bytes go to consecutive registers (index 127 wraps to 0); with it clear, every byte uses the same register.
- R7: In a read, the slave shifts out the pointed register MSB first, and after each acknowledged byte it sends the next register (auto-advance) or the same one again.
- R8: A NACK from the master ends the read: the slave releases SDA and drives nothing until the next start.
- R9: A start or stop condition in the middle of a byte abandons that byte with no write and restarts the address phase (start) or idles the slave (stop), and the pointer is kept.
- R10: The SDA pull-low enable changes only while SCL is low.
- R11: Out of reset, SDA is released and no write strobe is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock oversampling the bus |
| rst_n | input | 1 | Active-low asynchronous reset; the strap is captured while low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| addr_pin_i | input | 2 | Live address bits 1 and 0 |
| strap_i | input | 1 | Strap level giving address bit 2 |
| sda_pull_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| reg_addr_o | output | REG_AW | Register index (current pointer) |
| reg_wdata_o | output | 8 | Write data |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_rdata_i | input | 8 | Read data for reg_addr_o, combinational |

## Verification
The write strobe and the pointer advance happen on the same SCL falling edge. The strobe must carry the index from before the advance, and the next byte must land one register higher. The bench provokes this with auto-advance bursts, including one that crosses from index 127 to 0. It then judges the result by reading every touched register back over the bus and comparing each one with a shadow copy. That copy is updated in arithmetic from the bytes sent. Bursts with the flag clear check the opposite case: the value read back must be the last byte written, and the neighbouring register must be unchanged.

// File: rtl/i2c_regport_slave.sv
module i2c_regport_slave #(
  parameter logic [3:0] DEV_NIBBLE = 4'b0010,
  parameter int         REG_AW     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [1:0]        addr_pin_i,
  input  logic              strap_i,
  output logic              sda_pull_o,
  output logic [REG_AW-1:0] reg_addr_o,
  output logic [7:0]        reg_wdata_o,
  output logic              reg_we_o,
  input  logic [7:0]        reg_rdata_i
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_AACK, S_WR, S_WACK, S_RD, S_RACK} state_t;

  logic [2:0] scl_sr, sda_sr;
  logic       strap_q;
  state_t     state;
  logic [2:0] cnt;
  logic       full, rw, first, mack, ptr_inc;
  logic [7:0] sh, tx;
  logic [REG_AW-1:0] ptr_addr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sr <= 3'b111;
      sda_sr <= 3'b111;
    end else begin
      scl_sr <= {scl_sr[1:0], scl_i};
      sda_sr <= {sda_sr[1:0], sda_i};
    end

  always_ff @(posedge clk)
    if (!rst_n) strap_q <= strap_i;

  wire scl_s    = scl_sr[1];
  wire scl_q    = scl_sr[2];
  wire sda_s    = sda_sr[1];
  wire sda_q    = sda_sr[2];
  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start_c  = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  wire [6:0] my_addr = {DEV_NIBBLE, strap_q, addr_pin_i};

  assign reg_addr_o  = ptr_addr;
  assign reg_wdata_o = sh;
  assign reg_we_o    = scl_fall && state == S_WR && full && !first;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      full       <= 1'b0;
      sh         <= '0;
      tx         <= '0;
      rw         <= 1'b0;
      first      <= 1'b0;
      mack       <= 1'b0;
      ptr_inc    <= 1'b0;
      ptr_addr   <= '0;
      sda_pull_o <= 1'b0;
    end else if (start_c) begin
      state      <= S_ADDR;
      cnt        <= '0;
      full       <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (stop_c) begin
      state      <= S_IDLE;
      cnt        <= '0;
      full       <= 1'b0;
      sda_pull_o <= 1'b0;
    end else if (scl_rise) begin
      case (state)
        S_ADDR, S_WR: begin
          sh   <= {sh[6:0], sda_s};
          cnt  <= cnt + 3'd1;
          full <= (cnt == 3'd7);
        end
        S_RD: begin
          cnt  <= cnt + 3'd1;
          full <= (cnt == 3'd7);
        end
        S_RACK: mack <= ~sda_s;
        default: ;
      endcase
    end else if (scl_fall) begin
      case (state)
        S_ADDR:
          if (full) begin
            full <= 1'b0;
            if (sh[7:1] == my_addr) begin
              rw         <= sh[0];
              sda_pull_o <= 1'b1;
              state      <= S_AACK;
            end else begin
              state <= S_IDLE;
            end
          end
        S_AACK:
          if (rw) begin
            state      <= S_RD;
            tx         <= {reg_rdata_i[6:0], 1'b1};
            sda_pull_o <= ~reg_rdata_i[7];
          end else begin
            state      <= S_WR;
            first      <= 1'b1;
            sda_pull_o <= 1'b0;
          end
        S_WR:
          if (full) begin
            full       <= 1'b0;
            sda_pull_o <= 1'b1;
            state      <= S_WACK;
            first      <= 1'b0;
            if (first) begin
              ptr_inc  <= sh[7];
              ptr_addr <= sh[REG_AW-1:0];
            end else if (ptr_inc) begin
              ptr_addr <= ptr_addr + 1'b1;
            end
          end
        S_WACK: begin
          sda_pull_o <= 1'b0;
          state      <= S_WR;
        end
        S_RD:
          if (full) begin
            full       <= 1'b0;
            sda_pull_o <= 1'b0;
            state      <= S_RACK;
            if (ptr_inc) ptr_addr <= ptr_addr + 1'b1;
          end else begin
            sda_pull_o <= ~tx[7];
            tx         <= {tx[6:0], 1'b1};
          end
        S_RACK:
          if (mack) begin
            state      <= S_RD;
            tx         <= {reg_rdata_i[6:0], 1'b1};
            sda_pull_o <= ~reg_rdata_i[7];
          end else begin
            state      <= S_IDLE;
            sda_pull_o <= 1'b0;
          end
        default: ;
      endcase
    end

  AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !$past(scl_s)); // R10
  AST_PULL_OFF_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_o) |-> (!$past(scl_s) || $past(start_c) || $past(stop_c))); // R10
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IDLE |-> !sda_pull_o); // R4
  AST_WE_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> !sda_pull_o); // R5
  AST_PTR_HOLD_NOINC: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_addr != $past(ptr_addr)) && !$past(ptr_inc) |-> ($past(state) == S_WR && $past(first))); // R6

endmodule

// File: tb/i2c_regport_slave_tb.sv
module i2c_regport_slave_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic scl = 1'b1, m_sda = 1'b1, strap = 1'b0;
  logic [1:0] pins = 2'b00;
  logic sda_pull, we;
  logic [6:0] raddr;
  logic [7:0] wdata, rdata;
  wire sda = m_sda & ~sda_pull;

  logic [7:0] regs [128];
  logic [7:0] exp_regs [128];
  int checks = 0, fails = 0, we_count = 0, r10_bad = 0;
  logic pull_prev = 1'b0;
  bit ack;
  logic [7:0] d;
  int wc;

  i2c_regport_slave u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .addr_pin_i(pins),
    .strap_i(strap), .sda_pull_o(sda_pull), .reg_addr_o(raddr),
    .reg_wdata_o(wdata), .reg_we_o(we), .reg_rdata_i(rdata));

  assign rdata = regs[raddr];
  always @(posedge clk) if (we) regs[raddr] <= wdata;
  always @(negedge clk) begin
    if (we) we_count++;
    if (sda_pull !== pull_prev && scl) r10_bad++;
    pull_prev = sda_pull;
  end

  task automatic chk(input string req, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic tq; repeat (8) @(negedge clk); endtask
  task automatic bus_start; m_sda = 1; tq; scl = 1; tq; m_sda = 0; tq; scl = 0; tq; endtask
  task automatic bus_stop; m_sda = 0; tq; scl = 1; tq; m_sda = 1; tq; endtask
  task automatic bits_out(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin m_sda = b[i]; tq; scl = 1; tq; scl = 0; tq; end
  endtask
  task automatic send_byte(input logic [7:0] b, output bit a);
    bits_out(b, 8);
    m_sda = 1; tq; scl = 1; tq; a = (sda == 1'b0); scl = 0; tq;
  endtask
  task automatic recv_byte(input bit nack, output logic [7:0] v);
    m_sda = 1;
    for (int i = 7; i >= 0; i--) begin tq; scl = 1; tq; v[i] = sda; scl = 0; end
    tq; m_sda = nack; tq; scl = 1; tq; scl = 0; tq; m_sda = 1;
  endtask
  task automatic do_reset(input bit s);
    rst_n = 0; strap = s; repeat (4) @(negedge clk); rst_n = 1; repeat (2) @(negedge clk);
    strap = ~s;
  endtask
  task automatic finish_run;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  localparam logic [6:0] DEV = 7'h15;

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    finish_run;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin regs[i] = 8'(i * 37 + 5); exp_regs[i] = 8'(i * 37 + 5); end
    do_reset(1'b0);
    chk("R11 sda released", int'(sda_pull), 0);
    chk("R11 no strobe", we_count, 0);

    for (int s = 0; s < 2; s++) begin
      do_reset(s[0]);
      for (int p = 0; p < 4; p++) begin
        pins = 2'(p);
        for (int a = 0; a < 8; a++) begin
          bus_start; send_byte({4'b0010, 3'(a), 1'b0}, ack); bus_stop;
          chk("R1 R2 R3 address match", int'(ack), int'(a == s * 4 + p));
        end
      end
    end
    pins = 2'b01;

    bus_start;
    send_byte({7'h14, 1'b0}, ack); chk("R4 mismatch addr", int'(ack), 0);
    send_byte(8'h83, ack); chk("R4 ignored byte", int'(ack), 0);
    send_byte(8'h5A, ack); chk("R4 ignored byte", int'(ack), 0);
    bus_stop;
    chk("R4 no write", we_count, 0);

    bus_start;
    send_byte({DEV, 1'b0}, ack); chk("R5 addr ack", int'(ack), 1);
    send_byte(8'h8A, ack); chk("R5 ptr ack", int'(ack), 1);
    for (int k = 0; k < 4; k++) begin
      send_byte(8'hA0 + 8'(k), ack); chk("R5 data ack", int'(ack), 1);
      exp_regs[10 + k] = 8'hA0 + 8'(k);
    end
    bus_stop;
    chk("R5 strobe count", we_count, 4);

    bus_start; send_byte({DEV, 1'b0}, ack); send_byte(8'h8A, ack);
    bus_start; send_byte({DEV, 1'b1}, ack); chk("R7 read addr ack", int'(ack), 1);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k == 3, d); chk("R6 R7 auto-advance read", int'(d), int'(exp_regs[10 + k]));
    end
    bus_stop;

    bus_start; send_byte({DEV, 1'b1}, ack);
    recv_byte(1'b1, d); chk("R7 pointer kept across transactions", int'(d), int'(exp_regs[14]));
    recv_byte(1'b1, d); chk("R8 released after NACK", int'(d), 8'hFF);
    chk("R8 pull off", int'(sda_pull), 0);
    bus_stop;

    bus_start; send_byte({DEV, 1'b0}, ack); send_byte(8'h05, ack);
    send_byte(8'h11, ack); send_byte(8'h22, ack); send_byte(8'h33, ack);
    bus_stop;
    exp_regs[5] = 8'h33;
    bus_start; send_byte({DEV, 1'b0}, ack); send_byte(8'h05, ack);
    bus_start; send_byte({DEV, 1'b1}, ack);
    recv_byte(1'b0, d); chk("R6 fixed pointer write", int'(d), int'(exp_regs[5]));
    recv_byte(1'b1, d); chk("R7 fixed pointer reread", int'(d), int'(exp_regs[5]));
    bus_stop;
    bus_start; send_byte({DEV, 1'b0}, ack); send_byte(8'h06, ack);
    bus_start; send_byte({DEV, 1'b1}, ack);
    recv_byte(1'b1, d); chk("R6 neighbour untouched", int'(d), int'(exp_regs[6]));
    bus_stop;

    bus_start; send_byte({DEV, 1'b0}, ack); send_byte(8'hFF, ack);
    send_byte(8'hC1, ack); send_byte(8'hC2, ack); bus_stop;
    exp_regs[127] = 8'hC1; exp_regs[0] = 8'hC2;
    bus_start; send_byte({DEV, 1'b0}, ack); send_byte(8'hFF, ack);
    bus_start; send_byte({DEV, 1'b1}, ack);
    recv_byte(1'b0, d); chk("R6 top register", int'(d), int'(exp_regs[127]));
    recv_byte(1'b1, d); chk("R6 wrap to zero", int'(d), int'(exp_regs[0]));
    bus_stop;

    wc = we_count;
    bus_start; send_byte({DEV, 1'b0}, ack); send_byte(8'h94, ack);
    bits_out(8'h00, 4); bus_stop;
    chk("R9 stop mid-byte no write", we_count, wc);
    bus_start; send_byte({DEV, 1'b0}, ack); send_byte(8'h14, ack);
    bus_start; send_byte({DEV, 1'b1}, ack);
    recv_byte(1'b1, d); chk("R9 register intact", int'(d), int'(exp_regs[20]));
    bus_stop;

    bus_start; send_byte({DEV, 1'b0}, ack); send_byte(8'h9E, ack);
    bits_out(8'hFF, 3);
    bus_start; send_byte({DEV, 1'b1}, ack); chk("R9 start mid-byte readdress", int'(ack), 1);
    recv_byte(1'b1, d); chk("R9 pointer kept", int'(d), int'(exp_regs[30]));
    bus_stop;
    chk("R9 no stray write", we_count, wc);

    chk("R10 pull changes with SCL low", r10_bad, 0);
    finish_run;
  end
endmodule